// File: doc/BRIEF.md
# Ladder Bit-Logic Execution Unit

This block runs a stream of single-bit relay-logic instructions against a private bit memory. Each instruction names an operation and a bit address. It is accepted in the cycle its valid strobe is high and retires in that same clock edge. The block keeps a nine-bit status word that chains one instruction to the next: a first-check flag, the result of logic operation (RLO), a status copy of the last bit touched, an OR-precedence bit and a binary-result bit. Contacts read memory bits and fold them into the RLO. A coil instruction writes the RLO back into memory. A master-control-relay pair of inputs can force coil writes to 0.

A small two-state machine decides whether a contact starts a new logic string or extends the current one. In state STR_FIRST the first-check flag reads 0, and a contact loads its check result straight into the RLO. Any contact or XOR then moves the machine to STR_OPEN, where the flag reads 1 and later contacts combine with the RLO. The coil instruction moves the machine back to STR_FIRST. NOT and SAVE leave the state where it is. Synchronous reset puts it in STR_FIRST.

Top module: `lbl_exec_unit`

## Requirements
- R1: Synchronous reset clears every status bit and every memory bit to 0. Status layout: bit0 first-check, bit1 RLO, bit2 STA, bit3 OR, bits 7:4 always 0, bit8 BR.
- R2: When the first-check bit is 0, a contact or XOR loads its check result directly into the RLO. Every contact and XOR sets the first-check bit to 1.
- R3: Opcode 0 (normally open, series) checks 1 when the bit is 1. Opcode 1 (normally closed, series) checks 1 when the bit is 0. In a chained string the check is ANDed into the RLO. Both opcodes clear the OR bit.
- R4: Opcodes 2 (open) and 3 (closed) are parallel contacts. In a chained string the check is ORed into the RLO, and the OR bit takes the RLO value held just before the instruction. On a first check the OR bit becomes 0.
- R5: Opcode 4 (XOR) sets the RLO to the previous RLO XOR the addressed bit in a chained string, so two XORs in a row give 1 exactly when their two bits differ. It clears the OR bit.
- R6: Every contact and XOR copies the addressed bit, as read, into STA.
- R7: Opcode 6 (coil) writes a value into the addressed bit and sets STA to that value. It clears both the first-check bit and the OR bit, and leaves the RLO unchanged.
- R8: When mcr_zone is 1 and mcr_on is 0, the coil writes 0 whatever the RLO is. Otherwise it writes the RLO.
- R9: Opcode 5 (NOT) inverts the RLO, sets STA to 1, clears the OR bit and leaves the first-check bit unchanged.
- R10: Opcode 7 (save) copies the RLO into BR and changes no other status bit.
- R11: A contact in the cycle right after a coil to the same address reads the newly written value.
- R12: A cycle with ins_valid low changes neither the status word nor the memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ins_valid | input | 1 | Instruction strobe |
| ins_op | input | 3 | Opcode (0..7 as listed in the requirements) |
| ins_addr | input | ADDR_W | Bit address |
| mcr_zone | input | 1 | Coil lies inside a master-control zone |
| mcr_on | input | 1 | Master control relay energised |
| stat_word | output | 9 | Status word |

## Verification
Every ordered pair of contact-type opcodes runs on all four combinations of two stored bits. This separates the AND, OR and XOR folds from one another, and separates the first-check load from the chained combine. NOT, save and a coil follow each pair, so the handling of the OR bit and of BR is compared across all RLO values. A sweep of RLO, zone and relay states writes a coil and reads it back at once. This separates the master-control gate from plain assignment and exercises same-address read-after-write. A long pseudo-random stream mixes all opcodes with idle cycles, and a final read of all 256 bits checks both untouched bits and written ones.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

    localparam int STAT_W = 9;

    typedef enum logic [2:0] {
        OP_AND    = 3'd0,
        OP_ANDN   = 3'd1,
        OP_OR     = 3'd2,
        OP_ORN    = 3'd3,
        OP_XOR    = 3'd4,
        OP_NOT    = 3'd5,
        OP_ASSIGN = 3'd6,
        OP_SAVE   = 3'd7
    } lbl_op_e;

    typedef enum logic {
        STR_FIRST = 1'b0,
        STR_OPEN  = 1'b1
    } lbl_str_e;

    typedef struct packed {
        logic       br;
        logic [3:0] arith;
        logic       or_b;
        logic       sta;
        logic       rlo;
        logic       fc;
    } lbl_stat_t;

endpackage

// File: rtl/lbl_string_fsm.sv
module lbl_string_fsm
    import lbl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic open_str,
    input  logic close_str,
    output logic fc
);

    lbl_str_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            STR_FIRST: if (open_str)  st_d = STR_OPEN;
            STR_OPEN:  if (close_str) st_d = STR_FIRST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= STR_FIRST;
        else     st_q <= st_d;
    end

    always_comb begin
        fc = (st_q == STR_OPEN);
    end

    p_open_r2: assert property (@(posedge clk) disable iff (rst)
        open_str |=> fc);

    p_close_r7: assert property (@(posedge clk) disable iff (rst)
        close_str |=> !fc);

endmodule

// File: rtl/lbl_bit_mem.sv
module lbl_bit_mem #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              wbit,
    output logic              rbit
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0] bits_q;

    always_ff @(posedge clk) begin
        if (rst)     bits_q <= '0;
        else if (we) bits_q[addr] <= wbit;
    end

    always_comb begin
        rbit = bits_q[addr];
    end

    p_raw_r11: assert property (@(posedge clk) disable iff (rst)
        we |=> bits_q[$past(addr)] == $past(wbit));

endmodule

// File: rtl/lbl_rlo_alu.sv
module lbl_rlo_alu
    import lbl_pkg::*;
(
    input  logic      valid,
    input  lbl_op_e   op,
    input  logic      rd_bit,
    input  lbl_stat_t cur,
    input  logic      mcr_zone,
    input  logic      mcr_on,
    output logic      nxt_rlo,
    output logic      nxt_sta,
    output logic      nxt_or,
    output logic      nxt_br,
    output logic      open_str,
    output logic      close_str,
    output logic      wr_en,
    output logic      wr_bit
);

    logic chk;
    logic gated;

    always_comb begin
        gated     = mcr_zone & ~mcr_on;
        chk       = rd_bit;
        nxt_rlo   = cur.rlo;
        nxt_sta   = cur.sta;
        nxt_or    = cur.or_b;
        nxt_br    = cur.br;
        open_str  = 1'b0;
        close_str = 1'b0;
        wr_en     = 1'b0;
        wr_bit    = 1'b0;
        if (valid) begin
            unique case (op)
                OP_AND, OP_ANDN: begin
                    chk      = (op == OP_ANDN) ? ~rd_bit : rd_bit;
                    nxt_rlo  = cur.fc ? (cur.rlo & chk) : chk;
                    nxt_or   = 1'b0;
                    nxt_sta  = rd_bit;
                    open_str = 1'b1;
                end
                OP_OR, OP_ORN: begin
                    chk      = (op == OP_ORN) ? ~rd_bit : rd_bit;
                    nxt_rlo  = cur.fc ? (cur.rlo | chk) : chk;
                    nxt_or   = cur.fc & cur.rlo;
                    nxt_sta  = rd_bit;
                    open_str = 1'b1;
                end
                OP_XOR: begin
                    nxt_rlo  = cur.fc ? (cur.rlo ^ rd_bit) : rd_bit;
                    nxt_or   = 1'b0;
                    nxt_sta  = rd_bit;
                    open_str = 1'b1;
                end
                OP_NOT: begin
                    nxt_rlo = ~cur.rlo;
                    nxt_sta = 1'b1;
                    nxt_or  = 1'b0;
                end
                OP_ASSIGN: begin
                    wr_en     = 1'b1;
                    wr_bit    = cur.rlo & ~gated;
                    nxt_sta   = cur.rlo & ~gated;
                    nxt_or    = 1'b0;
                    close_str = 1'b1;
                end
                OP_SAVE: begin
                    nxt_br = cur.rlo;
                end
            endcase
        end
    end

endmodule

// File: rtl/lbl_exec_unit.sv
module lbl_exec_unit
    import lbl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [2:0]        ins_op,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic              mcr_zone,
    input  logic              mcr_on,
    output logic [8:0]        stat_word
);

    lbl_op_e   op;
    lbl_stat_t cur;
    logic      rlo_q, sta_q, or_q, br_q, fc;
    logic      nxt_rlo, nxt_sta, nxt_or, nxt_br;
    logic      open_str, close_str, wr_en, wr_bit, rd_bit;

    always_comb begin
        op        = lbl_op_e'(ins_op);
        cur       = '{br: br_q, arith: 4'b0000, or_b: or_q,
                      sta: sta_q, rlo: rlo_q, fc: fc};
        stat_word = cur;
    end

    lbl_bit_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk  (clk),
        .rst  (rst),
        .addr (ins_addr),
        .we   (wr_en),
        .wbit (wr_bit),
        .rbit (rd_bit)
    );

    lbl_rlo_alu u_alu (
        .valid     (ins_valid),
        .op        (op),
        .rd_bit    (rd_bit),
        .cur       (cur),
        .mcr_zone  (mcr_zone),
        .mcr_on    (mcr_on),
        .nxt_rlo   (nxt_rlo),
        .nxt_sta   (nxt_sta),
        .nxt_or    (nxt_or),
        .nxt_br    (nxt_br),
        .open_str  (open_str),
        .close_str (close_str),
        .wr_en     (wr_en),
        .wr_bit    (wr_bit)
    );

    lbl_string_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .open_str  (open_str),
        .close_str (close_str),
        .fc        (fc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rlo_q <= 1'b0;
            sta_q <= 1'b0;
            or_q  <= 1'b0;
            br_q  <= 1'b0;
        end else begin
            rlo_q <= nxt_rlo;
            sta_q <= nxt_sta;
            or_q  <= nxt_or;
            br_q  <= nxt_br;
        end
    end

    p_not_r9: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && op == OP_NOT) |=> (rlo_q == !$past(rlo_q)) && sta_q && (fc == $past(fc)));

    p_save_r10: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && op == OP_SAVE) |=> (br_q == $past(rlo_q)) && $stable(fc) && $stable(rlo_q));

    p_mcr_off_r8: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && op == OP_ASSIGN && mcr_zone && !mcr_on) |=> !sta_q);

    p_sta_r6: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> sta_q == $past(rd_bit));

    p_or_r4: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && (op == OP_OR || op == OP_ORN) && fc) |=> or_q == $past(rlo_q));

    p_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !ins_valid |=> $stable(stat_word));

endmodule

// File: tb/sim_lbl_exec_unit.sv
module sim_lbl_exec_unit;

    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ivalid = 1'b0;
    logic [2:0] iop = 3'd0;
    logic [7:0] iaddr = 8'd0;
    logic       mz = 1'b0;
    logic       mo = 1'b0;
    logic [8:0] sw;

    always #(CLK_NS/2) clk = ~clk;

    lbl_exec_unit #(.ADDR_W(8)) u0 (
        .clk       (clk),
        .rst       (rst),
        .ins_valid (ivalid),
        .ins_op    (iop),
        .ins_addr  (iaddr),
        .mcr_zone  (mz),
        .mcr_on    (mo),
        .stat_word (sw)
    );

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic m_mem [256];
    logic m_fc = 1'b0, m_rlo = 1'b0, m_sta = 1'b0, m_or = 1'b0, m_br = 1'b0;

    function automatic logic [8:0] mword();
        return {m_br, 4'b0000, m_or, m_sta, m_rlo, m_fc};
    endfunction

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0, 3'd1: return "R3";
            3'd2, 3'd3: return "R4";
            3'd4:       return "R5";
            3'd5:       return "R9";
            3'd6:       return "R7";
            default:    return "R10";
        endcase
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [2:0] op, input int a, input logic z, input logic o);
        logic b;
        logic c;
        logic w;
        b = m_mem[a];
        case (op)
            3'd0, 3'd1: begin
                c = (op == 3'd1) ? !b : b;
                m_rlo = m_fc ? (m_rlo & c) : c;
                m_or = 1'b0; m_sta = b; m_fc = 1'b1;
            end
            3'd2, 3'd3: begin
                c = (op == 3'd3) ? !b : b;
                m_or = m_fc & m_rlo;
                m_rlo = m_fc ? (m_rlo | c) : c;
                m_sta = b; m_fc = 1'b1;
            end
            3'd4: begin
                m_rlo = m_fc ? (m_rlo ^ b) : b;
                m_or = 1'b0; m_sta = b; m_fc = 1'b1;
            end
            3'd5: begin
                m_rlo = !m_rlo; m_sta = 1'b1; m_or = 1'b0;
            end
            3'd6: begin
                w = (z && !o) ? 1'b0 : m_rlo;
                m_mem[a] = w; m_sta = w; m_fc = 1'b0; m_or = 1'b0;
            end
            default: m_br = m_rlo;
        endcase
    endtask

    task automatic issue(input logic [2:0] op, input int a, input logic z, input logic o, input string tag);
        @(negedge clk);
        ivalid = 1'b1; iop = op; iaddr = a[7:0]; mz = z; mo = o;
        model(op, a, z, o);
        @(posedge clk);
        #1;
        ivalid = 1'b0;
        check(tag, sw, mword());
    endtask

    task automatic idle(input logic [2:0] op, input int a);
        @(negedge clk);
        ivalid = 1'b0; iop = op; iaddr = a[7:0]; mz = 1'b1; mo = 1'b0;
        @(posedge clk);
        #1;
        check("R12", sw, mword());
    endtask

    task automatic setbit(input int a, input logic v);
        issue(v ? 3'd1 : 3'd0, 0, 1'b0, 1'b0, "R3");
        issue(3'd6, a, 1'b0, 1'b0, "R7");
    endtask

    initial begin
        #(CLK_NS * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R12 watchdog actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < 256; i++) m_mem[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", sw, 9'h000);

        // contact pairs over all stored-bit combinations
        for (int op1 = 0; op1 < 5; op1++) begin
            for (int op2 = 0; op2 < 5; op2++) begin
                for (int v = 0; v < 4; v++) begin
                    setbit(10, v[0]);
                    setbit(11, v[1]);
                    issue(op1[2:0], 10, 1'b0, 1'b0, "R2");
                    check("R6", {8'd0, sw[2]}, {8'd0, v[0]});
                    issue(op2[2:0], 11, 1'b0, 1'b0, tag_of(op2[2:0]));
                    if (op1 == 4 && op2 == 4)
                        check("R5", {8'd0, sw[1]}, {8'd0, v[0] ^ v[1]});
                    issue(3'd7, 0, 1'b0, 1'b0, "R10");
                    issue(3'd5, 0, 1'b0, 1'b0, "R9");
                    issue(3'd6, 12, 1'b0, 1'b0, "R7");
                end
            end
        end

        // master control gate, with immediate readback
        for (int k = 0; k < 8; k++) begin
            setbit(13, k[0]);
            issue(3'd6, 14, k[1], k[2], "R8");
            issue(3'd0, 14, 1'b0, 1'b0, "R11");
            check("R8", {8'd0, sw[1]}, {8'd0, (k[1] && !k[2]) ? 1'b0 : k[0]});
            issue(3'd6, 15, 1'b0, 1'b0, "R7");
        end

        // idle cycles must not disturb anything
        issue(3'd1, 0, 1'b0, 1'b0, "R2");
        for (int k = 0; k < 8; k++) idle(k[2:0], 14);
        issue(3'd0, 14, 1'b0, 1'b0, "R12");

        // pseudo-random stream
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[15:13] == 3'd0)
                idle(lf[2:0], 1 + int'(lf[7:0]) % 200);
            else
                issue(lf[2:0], 1 + int'(lf[10:3]) % 200, lf[11], lf[12], tag_of(lf[2:0]));
        end

        // read back every bit
        issue(3'd6, 201, 1'b0, 1'b0, "R7");
        for (int a = 0; a < 256; a++) begin
            issue(3'd0, a, 1'b0, 1'b0, "R1");
            issue(3'd6, a, 1'b0, 1'b0, "R11");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule